// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital controller of an 8-bit successive-approximation analog-to-digital converter. It latches a channel number and holds the sample switch closed for a fixed number of clock cycles. It then asserts hold and works through the bits from the most significant to the least significant. On each trial it presents a code to an external resistor-string tap selector and reads back a one-bit comparator decision.

When the last bit is decided, the finished code is copied into a result register, and a one-cycle end-of-conversion pulse is raised in the same cycle. While the enable input stays high, the sequencer starts a new sample phase at once. The first result after enable rises is flagged as invalid, so that software can drop it. Dropping enable abandons the conversion in flight, and the last good result is kept.

Top module: `sar_conv_seq`

## Requirements
- R1: After reset, `sample_ctl`, `hold`, `eoc_irq` and `result_invalid` are 0, and `trial_code`, `result` and `chan_out` are all zero.
- R2: When `enable` is seen high while idle, `sample_ctl` is high for exactly SAMPLE_CYC cycles with `trial_code` at zero. Then `hold` is high for exactly NBITS cycles, one for each bit trial. `sample_ctl` and `hold` are never high together.
- R3: In the first trial cycle, `trial_code` has only its most significant bit set (0x80 for 8 bits).
- R4: At the end of each trial cycle, the bit under test is kept if `cmp_hi` is 1 (input at or above the tap) and cleared if it is 0. The next lower bit is then set. So after a first decision of 1 the second code is 0xC0, and after 0 it is 0x40. With an ideal comparator, the result equals the input code.
- R5: `result` changes only at the end of a conversion. In that cycle, and only then, `eoc_irq` is high for one cycle, and `result` holds the final code in that same cycle.
- R6: `result_invalid` is 1 alongside the first result produced after `enable` rises from idle, and 0 alongside every later result.
- R7: While `enable` stays high, a new sample phase begins in the cycle that `eoc_irq` is high.
- R8: If `enable` is low at a clock edge during sampling or trials, the block is idle in the next cycle, with `sample_ctl` and `hold` at 0. No `eoc_irq` follows, and `result` is unchanged.
- R9: `chan_sel` is captured onto `chan_out` at the start of each sample phase and held until the next one starts. A change made during a conversion affects only the next conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Run conversions while high; low aborts |
| chan_sel | input | CH_W | Requested analog channel |
| cmp_hi | input | 1 | Comparator: 1 when input is at or above the tap |
| sample_ctl | output | 1 | Sample switch closed |
| hold | output | 1 | Hold asserted during bit trials |
| chan_out | output | CH_W | Channel used by the current conversion |
| trial_code | output | NBITS | Code driving the tap selector |
| result | output | NBITS | Last completed conversion |
| result_invalid | output | 1 | Current result is the first after enable |
| eoc_irq | output | 1 | End-of-conversion pulse |

## Verification
The assertions assume that `cmp_hi` settles within the cycle in which `trial_code` is presented. They also assume that `enable` is low while reset is applied, and that inputs change away from the rising edge. The bench drives every input on the falling edge and keeps `enable` low during reset. It derives `cmp_hi` in the same cycle from an ideal comparison between a per-channel stimulus value and the presented code. Stimulus values change only after a result is seen, while the new conversion is still in its sample phase, so no trial ever sees a moving input.

// File: rtl/sar_pkg.sv
// Shared types for the successive-approximation sequencer.
// Assumes nothing beyond the IEEE 1800-2017 enum semantics.
package sar_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SAMPLE = 2'd1,
        ST_TRIAL  = 2'd2
    } seq_state_t;
endpackage

// File: rtl/sar_sample_timer.sv
// Sample-phase timer: counts cycles while run is high and flags the last one.
// Assumes SAMPLE_CYC >= 1; the counter restarts from zero whenever run drops.
module sar_sample_timer #(
    parameter int SAMPLE_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);
    localparam int CW = (SAMPLE_CYC > 1) ? $clog2(SAMPLE_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(SAMPLE_CYC - 1);

    logic [CW-1:0] cnt;

    // Advance while sampling, clear otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (cnt != LAST) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign done = run && (cnt == LAST);
endmodule

// File: rtl/sar_approx_reg.sv
// Approximation register: holds the trial code and the index of the bit under test.
// Assumes clr, load and step are mutually exclusive in use; clr wins, then load.
module sar_approx_reg #(
    parameter int NBITS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             load,
    input  logic             step,
    input  logic             cmp_hi,
    output logic [NBITS-1:0] code,
    output logic [NBITS-1:0] resolved,
    output logic             last
);
    localparam int IW = (NBITS > 1) ? $clog2(NBITS) : 1;
    localparam logic [IW-1:0] TOP = IW'(NBITS - 1);

    logic [IW-1:0]    idx;
    logic [NBITS-1:0] cur_bit;
    logic [NBITS-1:0] next_bit;

    // One-hot decode of the bit under test.
    for (genvar i = 0; i < NBITS; i++) begin : g_dec
        assign cur_bit[i] = (idx == IW'(i));
    end

    assign next_bit = cur_bit >> 1;

    // Replace the bit under test with the comparator decision.
    always_comb begin
        resolved = cmp_hi ? (code | cur_bit) : (code & ~cur_bit);
    end

    assign last = (idx == '0);

    // Update the code and the bit index one trial at a time.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            code <= '0;
            idx  <= TOP;
        end else if (load) begin
            code <= {1'b1, {(NBITS-1){1'b0}}};
            idx  <= TOP;
        end else if (step) begin
            code <= resolved | next_bit;
            idx  <= idx - 1'b1;
        end
    end
endmodule

// File: rtl/sar_result_reg.sv
// Result register: latches the final code, its validity flag and the end pulse.
// Assumes arm and done do not coincide; done consumes the pending first-result mark.
module sar_result_reg #(
    parameter int NBITS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm,
    input  logic             done,
    input  logic [NBITS-1:0] final_code,
    output logic [NBITS-1:0] result,
    output logic             result_invalid,
    output logic             eoc_irq
);
    logic first_pending;

    // Mark the next result as the first one after enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            first_pending <= 1'b0;
        end else if (arm) begin
            first_pending <= 1'b1;
        end else if (done) begin
            first_pending <= 1'b0;
        end
    end

    // Latch the result and raise the end pulse on completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result         <= '0;
            result_invalid <= 1'b0;
            eoc_irq        <= 1'b0;
        end else begin
            eoc_irq <= done;
            if (done) begin
                result         <= final_code;
                result_invalid <= first_pending;
            end
        end
    end
endmodule

// File: rtl/sar_conv_seq.sv
// Sequencer top: idle -> sample -> bit trials -> result, restarting while enabled.
// Assumes cmp_hi reflects trial_code within the same cycle; enable low aborts at once.
module sar_conv_seq
    import sar_pkg::*;
#(
    parameter int NBITS      = 8,
    parameter int CH_W       = 3,
    parameter int SAMPLE_CYC = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [CH_W-1:0]  chan_sel,
    input  logic             cmp_hi,
    output logic             sample_ctl,
    output logic             hold,
    output logic [CH_W-1:0]  chan_out,
    output logic [NBITS-1:0] trial_code,
    output logic [NBITS-1:0] result,
    output logic             result_invalid,
    output logic             eoc_irq
);
    seq_state_t       state;
    seq_state_t       state_nx;
    logic             smp_done;
    logic             bit_last;
    logic             load_msb;
    logic             do_step;
    logic             clr_code;
    logic             finish;
    logic             start_first;
    logic             capture_ch;
    logic [NBITS-1:0] resolved;
    logic [CH_W-1:0]  chan_q;

    assign start_first = (state == ST_IDLE) && enable;
    assign load_msb    = (state == ST_SAMPLE) && enable && smp_done;
    assign do_step     = (state == ST_TRIAL) && enable && !bit_last;
    assign finish      = (state == ST_TRIAL) && enable && bit_last;
    assign clr_code    = !load_msb && !do_step;
    assign capture_ch  = start_first || finish;

    // Next-state selection; enable low always returns to idle.
    always_comb begin
        state_nx = state;
        if (!enable) begin
            state_nx = ST_IDLE;
        end else begin
            case (state)
                ST_IDLE:   state_nx = ST_SAMPLE;
                ST_SAMPLE: if (smp_done) state_nx = ST_TRIAL;
                ST_TRIAL:  if (bit_last) state_nx = ST_SAMPLE;
                default:   state_nx = ST_IDLE;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Capture the channel at the start of each sample phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chan_q <= '0;
        end else if (capture_ch) begin
            chan_q <= chan_sel;
        end
    end

    sar_sample_timer #(.SAMPLE_CYC(SAMPLE_CYC)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   ((state == ST_SAMPLE) && enable),
        .done  (smp_done)
    );

    sar_approx_reg #(.NBITS(NBITS)) u_sar (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr_code),
        .load     (load_msb),
        .step     (do_step),
        .cmp_hi   (cmp_hi),
        .code     (trial_code),
        .resolved (resolved),
        .last     (bit_last)
    );

    sar_result_reg #(.NBITS(NBITS)) u_res (
        .clk            (clk),
        .rst_n          (rst_n),
        .arm            (start_first),
        .done           (finish),
        .final_code     (resolved),
        .result         (result),
        .result_invalid (result_invalid),
        .eoc_irq        (eoc_irq)
    );

    assign sample_ctl = (state == ST_SAMPLE);
    assign hold       = (state == ST_TRIAL);
    assign chan_out   = chan_q;
endmodule

// File: rtl/sar_conv_seq_chk.sv
// Property checker for the sequencer, attached to every instance by bind.
// Assumes enable is low during reset and cmp_hi is settled when sampled.
module sar_conv_seq_chk #(
    parameter int NBITS = 8,
    parameter int CH_W  = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             enable,
    input logic             sample_ctl,
    input logic             hold,
    input logic [CH_W-1:0]  chan_out,
    input logic [NBITS-1:0] trial_code,
    input logic [NBITS-1:0] result,
    input logic             eoc_irq
);
    localparam logic [NBITS-1:0] MSB_ONLY = {1'b1, {(NBITS-1){1'b0}}};

    p_phase_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(sample_ctl && hold));

    p_code_zero_sample_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sample_ctl |-> (trial_code == '0));

    p_msb_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold) |-> (trial_code == MSB_ONLY));

    p_result_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !eoc_irq) |-> $stable(result));

    p_eoc_after_trials_r5: assert property (@(posedge clk) disable iff (!rst_n)
        eoc_irq |-> $past(hold));

    p_eoc_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        eoc_irq |=> !eoc_irq);

    p_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (eoc_irq && $past(enable)) |-> sample_ctl);

    p_abort_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!sample_ctl && !hold && !eoc_irq));

    p_chan_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && $past(hold)) |-> $stable(chan_out));
endmodule

bind sar_conv_seq sar_conv_seq_chk #(.NBITS(NBITS), .CH_W(CH_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .sample_ctl (sample_ctl),
    .hold       (hold),
    .chan_out   (chan_out),
    .trial_code (trial_code),
    .result     (result),
    .eoc_irq    (eoc_irq)
);

// File: tb/sar_conv_seq_test.sv
// Bench: behavioural per-cycle reference model plus directed scenarios.
module sar_conv_seq_test;
    localparam int NB = 8;
    localparam int CW = 3;
    localparam int SC = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          enable = 1'b0;
    logic [CW-1:0] chan_sel = '0;
    logic          cmp_hi;
    logic          sample_ctl, hold, result_invalid, eoc_irq;
    logic [CW-1:0] chan_out;
    logic [NB-1:0] trial_code, result;
    logic [NB-1:0] vin [8];

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    assign cmp_hi = (vin[chan_out] >= trial_code);

    sar_conv_seq #(.NBITS(NB), .CH_W(CW), .SAMPLE_CYC(SC)) uut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .chan_sel(chan_sel),
        .cmp_hi(cmp_hi), .sample_ctl(sample_ctl), .hold(hold),
        .chan_out(chan_out), .trial_code(trial_code), .result(result),
        .result_invalid(result_invalid), .eoc_irq(eoc_irq)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Reference model: 0 idle, 1 sampling, 2 trials.
    int m_st = 0, m_cnt = 0, m_code = 0, m_bit = 0, m_chan = 0;
    int m_res = 0, m_inv = 0, m_eoc = 0, m_first = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; m_code = 0; m_bit = 0; m_chan = 0;
            m_res = 0; m_inv = 0; m_eoc = 0; m_first = 0;
        end else begin
            m_eoc = 0;
            if (!enable) begin
                m_st = 0; m_code = 0;
            end else if (m_st == 0) begin
                m_st = 1; m_cnt = 0; m_code = 0; m_chan = chan_sel; m_first = 1;
            end else if (m_st == 1) begin
                if (m_cnt == SC - 1) begin
                    m_st = 2; m_code = 1 << (NB - 1); m_bit = NB - 1;
                end else begin
                    m_cnt++;
                end
            end else begin
                if (!(int'(vin[m_chan]) >= m_code)) m_code -= (1 << m_bit);
                if (m_bit == 0) begin
                    m_res = m_code; m_inv = m_first; m_first = 0; m_eoc = 1;
                    m_st = 1; m_cnt = 0; m_code = 0; m_chan = chan_sel;
                end else begin
                    m_bit--;
                    m_code += (1 << m_bit);
                end
            end
        end
    end

    // Per-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            check(sample_ctl == (m_st == 1), "R2 sample_ctl", sample_ctl, m_st == 1);
            check(hold == (m_st == 2), "R2 hold", hold, m_st == 2);
            check(int'(trial_code) == m_code, "R4 trial_code", trial_code, m_code);
            check(eoc_irq == m_eoc[0], "R5 eoc_irq", eoc_irq, m_eoc);
            check(int'(result) == m_res, "R5 result", result, m_res);
            check(result_invalid == m_inv[0], "R6 result_invalid", result_invalid, m_inv);
            check(int'(chan_out) == m_chan, "R9 chan_out", chan_out, m_chan);
        end
    end

    // Wait on falling edges until eoc is seen; returns edges waited.
    task automatic wait_eoc(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!eoc_irq && n < 200);
    endtask

    initial begin
        int n;
        logic [NB-1:0] keep;
        for (int i = 0; i < 8; i++) vin[i] = NB'(i * 37 + 5);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(!sample_ctl && !hold && !eoc_irq && !result_invalid, "R1 flags",
              {sample_ctl, hold, eoc_irq, result_invalid}, 0);
        check(result == 0 && trial_code == 0 && chan_out == 0, "R1 data", result, 0);

        // First conversion on channel 2, first-result flag
        vin[2] = 8'hA5; chan_sel = 3'd2; enable = 1'b1;
        wait_eoc(n);
        check(n == 1 + SC + NB, "R2 latency", n, 1 + SC + NB);
        check(result == 8'hA5, "R4 result A5", result, 8'hA5);
        check(result_invalid == 1'b1, "R6 first invalid", result_invalid, 1);
        check(sample_ctl == 1'b1, "R7 restart", sample_ctl, 1);

        // Walk through boundary codes; inputs change during sampling only
        foreach (vin[k]) if (k == 0) begin end
        for (int j = 0; j < 6; j++) begin
            logic [NB-1:0] v;
            case (j)
                0: v = 8'h00; 1: v = 8'hFF; 2: v = 8'h80;
                3: v = 8'h7F; 4: v = 8'h01; default: v = 8'h5A;
            endcase
            vin[2] = v;
            wait_eoc(n);
            check(result == v, "R4 boundary code", result, v);
            check(result_invalid == 1'b0, "R6 later valid", result_invalid, 0);
        end

        // R3/R4: first and second trial codes
        vin[2] = 8'hC3;
        while (!hold) @(negedge clk);
        check(trial_code == 8'h80, "R3 msb trial", trial_code, 8'h80);
        @(negedge clk);
        check(trial_code == 8'hC0, "R4 second trial hi", trial_code, 8'hC0);
        wait_eoc(n);
        vin[2] = 8'h33;
        while (!hold) @(negedge clk);
        @(negedge clk);
        check(trial_code == 8'h40, "R4 second trial lo", trial_code, 8'h40);

        // R9: channel change mid-conversion applies next time
        vin[5] = 8'h3C;
        chan_sel = 3'd5;
        @(negedge clk);
        check(chan_out == 3'd2, "R9 channel held", chan_out, 2);
        wait_eoc(n);
        check(result == 8'h33, "R9 old channel result", result, 8'h33);
        check(chan_out == 3'd5, "R9 new channel captured", chan_out, 5);
        wait_eoc(n);
        check(result == 8'h3C, "R9 new channel result", result, 8'h3C);

        // R8: abort during trials keeps result, no eoc
        keep = result;
        while (!hold) @(negedge clk);
        repeat (3) @(negedge clk);
        enable = 1'b0;
        @(negedge clk);
        check(!hold && !sample_ctl, "R8 idle after abort", {hold, sample_ctl}, 0);
        n = 0;
        repeat (30) begin
            @(negedge clk);
            if (eoc_irq) n++;
        end
        check(n == 0, "R8 no eoc after abort", n, 0);
        check(result == keep, "R8 result kept", result, keep);

        // R8: abort during sampling, then R6 flag re-armed
        enable = 1'b1;
        repeat (4) @(negedge clk);
        enable = 1'b0;
        @(negedge clk);
        check(!sample_ctl, "R8 abort in sample", sample_ctl, 0);
        check(result == keep, "R8 result kept 2", result, keep);
        enable = 1'b1;
        wait_eoc(n);
        check(result_invalid == 1'b1, "R6 invalid after re-enable", result_invalid, 1);
        wait_eoc(n);
        check(result_invalid == 1'b0, "R6 valid after re-enable", result_invalid, 0);
        enable = 1'b0;
        repeat (3) @(negedge clk);

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule